// File: doc/BRIEF.md
# Outbound Address Translation Windows

This block maps addresses seen on the local (CPU-side) bus onto the PCI bus address space through a small set of programmable windows. Two of the windows are fully programmable: each has a 64-bit local base, a 64-bit PCI base and a 32-bit span register. The span register holds a mask whose bit 0 enables the window. A third, trailing window has only a span register. Writes to that register are stored and can be read back, but they never open a mapping.

An incoming local address is compared against both full windows on every cycle. When the address falls inside an enabled window, the block reports a hit. It also reports the PCI address, which is the window's PCI base plus the offset of the address into the window. When both windows claim the address, the lower-numbered window wins. When no window claims it, a miss flag is raised.

Configuration goes through a 32-bit word register port addressed by byte offset. Read data and translation results are registered and appear one clock after their inputs are presented.

Top module: `obwin_xlate`

## Requirements
- R1: While `rst` is high, all base and span registers are cleared to zero. In the first cycle after reset, `cfg_rdata` is 0, `xl_miss` is 1, `xl_hit` is 0 and `bus_addr` is 0.
- R2: Window w (w = 0 or 1) has its registers at byte offset 0x68 + 0x14*w plus a field offset. The field offsets are +0x0 local-base bits 31:0, +0x4 local-base bits 63:32, +0x8 span, +0xC PCI-base bits 31:0 and +0x10 PCI-base bits 63:32. The trailing window's span register is at 0x90. A value written to any of these offsets is returned on `cfg_rdata` one cycle after that offset is presented.
- R3: A write to a low-half offset changes only bits 31:0 of its 64-bit base. A write to a high-half offset changes only bits 63:32.
- R4: A window whose span bit 0 is 0 never produces a hit, whatever its bases are.
- R5: A window's length is (~(span & 0xFFFFFFFE) + 1) taken modulo 2^32, and a length of 0 is replaced by 0xFFFFFFFF. An enabled window claims an address A when local_base <= A and A - local_base < length.
- R6: On a hit, `bus_addr` = PCI base + (A - local base), computed modulo 2^64.
- R7: When both full windows claim the address, window 0 supplies `bus_addr`.
- R8: The trailing window's span register is stored and readable, but it never produces a hit.
- R9: Exactly one of `xl_hit` and `xl_miss` is 1 in every cycle. On a miss, `bus_addr` is 0.
- R10: A read of any offset outside the map of R2, including offsets that are not multiples of 4, returns 0. A write to such an offset changes no register and no translation.
- R11: `bus_addr`, `xl_hit` and `xl_miss` change only at a rising clock edge. They reflect the `loc_addr` and register contents sampled at that edge. `cfg_rdata` likewise reflects the offset sampled at the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Register write strobe |
| cfg_ofs | input | 8 | Register byte offset for reads and writes |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for the offset sampled at the last edge |
| loc_addr | input | 64 | Local bus address to translate |
| bus_addr | output | 64 | Translated PCI address, zero on a miss |
| xl_hit | output | 1 | A full window claimed the address |
| xl_miss | output | 1 | No window claimed the address |

## Verification
Some properties hold on every cycle, and the bound checker watches those: hit and miss are exclusive, a miss forces a zero address, reads of unmapped offsets return zero, the state after reset is clean, and the outputs hold steady while the address and the registers are quiet. The window arithmetic depends on register contents, so only the bench's sweeps can show it. These cover the two's-complement span and its zero-to-maximum substitution at every power-of-two length, the inclusive and exclusive window edges, the 64-bit wrap of the translated address, the priority between overlapping windows, half-word register updates, and the trailing window that never maps.

// File: rtl/obwin_pkg.sv
package obwin_pkg;
  localparam int LOC_W = 64;
  localparam int PCI_W = 64;
  localparam int REG_W = 32;
  localparam int OFS_W = 8;

  typedef struct packed {
    logic [LOC_W-1:0] loc_base;
    logic [PCI_W-1:0] bus_base;
    logic [REG_W-1:0] span;
  } win_cfg_t;

  // field offsets inside one full window
  localparam logic [OFS_W-1:0] F_LOC_LO = 8'h00;
  localparam logic [OFS_W-1:0] F_LOC_HI = 8'h04;
  localparam logic [OFS_W-1:0] F_SPAN   = 8'h08;
  localparam logic [OFS_W-1:0] F_BUS_LO = 8'h0C;
  localparam logic [OFS_W-1:0] F_BUS_HI = 8'h10;

  // window length from the span mask; bit 0 is the enable, not a size bit
  function automatic logic [REG_W-1:0] span_len(input logic [REG_W-1:0] span);
    logic [REG_W-1:0] m;
    logic [REG_W-1:0] s;
    m = span & ~REG_W'(1);
    s = ~m + REG_W'(1);
    if (s == '0) s = '1;
    return s;
  endfunction
endpackage

// File: rtl/obwin_regs.sv
module obwin_regs
  import obwin_pkg::*;
#(
  parameter int                NUM_FULL = 2,
  parameter logic [OFS_W-1:0]  BASE     = 8'h68,
  parameter logic [OFS_W-1:0]  STRIDE   = 8'h14
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [OFS_W-1:0]               ofs,
  input  logic [REG_W-1:0]               wdata,
  output win_cfg_t [NUM_FULL-1:0]        cfg,
  output logic [REG_W-1:0]               rdata
);
  localparam int HALF = REG_W;

  function automatic logic [OFS_W-1:0] fofs(input int w, input logic [OFS_W-1:0] f);
    return OFS_W'(int'(BASE) + int'(STRIDE) * w + int'(f));
  endfunction

  localparam logic [OFS_W-1:0] TAIL_OFS = OFS_W'(int'(BASE) + int'(STRIDE) * NUM_FULL);

  logic [REG_W-1:0] tail_span;
  logic [REG_W-1:0] rd_nxt;

  for (genvar gi = 0; gi < NUM_FULL; gi++) begin : g_win
    localparam logic [OFS_W-1:0] O_LL = fofs(gi, F_LOC_LO);
    localparam logic [OFS_W-1:0] O_LH = fofs(gi, F_LOC_HI);
    localparam logic [OFS_W-1:0] O_SP = fofs(gi, F_SPAN);
    localparam logic [OFS_W-1:0] O_BL = fofs(gi, F_BUS_LO);
    localparam logic [OFS_W-1:0] O_BH = fofs(gi, F_BUS_HI);
    win_cfg_t r;
    always_ff @(posedge clk) begin
      if (rst) begin
        r <= '0;
      end else if (wr_en) begin
        case (ofs)
          O_LL: r.loc_base[HALF-1:0]      <= wdata;
          O_LH: r.loc_base[LOC_W-1:HALF]  <= wdata;
          O_SP: r.span                    <= wdata;
          O_BL: r.bus_base[HALF-1:0]      <= wdata;
          O_BH: r.bus_base[PCI_W-1:HALF]  <= wdata;
          default: ;
        endcase
      end
    end
    assign cfg[gi] = r;
  end

  always_ff @(posedge clk) begin
    if (rst) tail_span <= '0;
    else if (wr_en && ofs == TAIL_OFS) tail_span <= wdata;
  end

  always_comb begin
    rd_nxt = '0;
    for (int i = 0; i < NUM_FULL; i++) begin
      if (ofs == fofs(i, F_LOC_LO)) rd_nxt = cfg[i].loc_base[HALF-1:0];
      if (ofs == fofs(i, F_LOC_HI)) rd_nxt = cfg[i].loc_base[LOC_W-1:HALF];
      if (ofs == fofs(i, F_SPAN))   rd_nxt = cfg[i].span;
      if (ofs == fofs(i, F_BUS_LO)) rd_nxt = cfg[i].bus_base[HALF-1:0];
      if (ofs == fofs(i, F_BUS_HI)) rd_nxt = cfg[i].bus_base[PCI_W-1:HALF];
    end
    if (ofs == TAIL_OFS) rd_nxt = tail_span;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_nxt;
  end
endmodule

// File: rtl/obwin_match.sv
module obwin_match
  import obwin_pkg::*;
(
  input  win_cfg_t          cfg,
  input  logic [LOC_W-1:0]  loc,
  output logic              hit,
  output logic [PCI_W-1:0]  bus
);
  logic [LOC_W-1:0] off;
  logic [REG_W-1:0] len;

  always_comb begin
    len = span_len(cfg.span);
    off = loc - cfg.loc_base;
    hit = cfg.span[0] && (loc >= cfg.loc_base) && (off < LOC_W'(len));
    bus = cfg.bus_base + PCI_W'(off);
  end
endmodule

// File: rtl/obwin_pick.sv
module obwin_pick
  import obwin_pkg::*;
#(
  parameter int NUM_FULL = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_FULL-1:0]             hits,
  input  logic [NUM_FULL-1:0][PCI_W-1:0]  buses,
  output logic [PCI_W-1:0]                bus_q,
  output logic                            hit_q,
  output logic                            miss_q
);
  logic             sel_hit;
  logic [PCI_W-1:0] sel_bus;

  // scan from the top so the lowest index is written last and wins
  always_comb begin
    sel_hit = 1'b0;
    sel_bus = '0;
    for (int i = NUM_FULL - 1; i >= 0; i--) begin
      if (hits[i]) begin
        sel_hit = 1'b1;
        sel_bus = buses[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_q  <= '0;
      hit_q  <= 1'b0;
      miss_q <= 1'b1;
    end else begin
      bus_q  <= sel_bus;
      hit_q  <= sel_hit;
      miss_q <= !sel_hit;
    end
  end
endmodule

// File: rtl/obwin_xlate.sv
module obwin_xlate
  import obwin_pkg::*;
#(
  parameter int                NUM_FULL = 2,
  parameter logic [OFS_W-1:0]  BASE     = 8'h68,
  parameter logic [OFS_W-1:0]  STRIDE   = 8'h14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [OFS_W-1:0]  cfg_ofs,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic [LOC_W-1:0]  loc_addr,
  output logic [PCI_W-1:0]  bus_addr,
  output logic              xl_hit,
  output logic              xl_miss
);
  win_cfg_t [NUM_FULL-1:0]            cfg;
  logic [NUM_FULL-1:0]                hits;
  logic [NUM_FULL-1:0][PCI_W-1:0]     buses;

  obwin_regs #(.NUM_FULL(NUM_FULL), .BASE(BASE), .STRIDE(STRIDE)) regs_i (
    .clk   (clk),
    .rst   (rst),
    .wr_en (cfg_wr),
    .ofs   (cfg_ofs),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .rdata (cfg_rdata)
  );

  for (genvar gi = 0; gi < NUM_FULL; gi++) begin : g_cmp
    obwin_match match_i (
      .cfg (cfg[gi]),
      .loc (loc_addr),
      .hit (hits[gi]),
      .bus (buses[gi])
    );
  end

  obwin_pick #(.NUM_FULL(NUM_FULL)) pick_i (
    .clk    (clk),
    .rst    (rst),
    .hits   (hits),
    .buses  (buses),
    .bus_q  (bus_addr),
    .hit_q  (xl_hit),
    .miss_q (xl_miss)
  );
endmodule

// File: rtl/obwin_xlate_chk.sv
module obwin_xlate_chk
  import obwin_pkg::*;
#(
  parameter int                NUM_FULL = 2,
  parameter logic [OFS_W-1:0]  BASE     = 8'h68,
  parameter logic [OFS_W-1:0]  STRIDE   = 8'h14
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr,
  input logic [OFS_W-1:0]  cfg_ofs,
  input logic [REG_W-1:0]  cfg_rdata,
  input logic [LOC_W-1:0]  loc_addr,
  input logic [PCI_W-1:0]  bus_addr,
  input logic              xl_hit,
  input logic              xl_miss
);
  localparam int LAST = int'(BASE) + int'(STRIDE) * NUM_FULL;

  function automatic logic is_mapped(input logic [OFS_W-1:0] o);
    return (o[1:0] == 2'b00) && (int'(o) >= int'(BASE)) && (int'(o) <= LAST);
  endfunction

  logic [1:0] live;
  always_ff @(posedge clk) begin
    if (rst) live <= '0;
    else if (live != 2'd3) live <= live + 2'd1;
  end

  assert_hit_xor_miss_R9: assert property (@(posedge clk) disable iff (rst)
    xl_hit != xl_miss);

  assert_miss_zero_addr_R9: assert property (@(posedge clk) disable iff (rst)
    xl_miss |-> bus_addr == '0);

  assert_reset_clean_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (xl_miss && !xl_hit && cfg_rdata == '0 && bus_addr == '0));

  assert_unmapped_read_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !is_mapped($past(cfg_ofs)) |-> cfg_rdata == '0);

  assert_quiet_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (live == 2'd3 && $past(loc_addr) == $past(loc_addr, 2) && !$past(cfg_wr, 2))
      |-> ($stable(bus_addr) && $stable(xl_hit)));
endmodule

bind obwin_xlate obwin_xlate_chk #(.NUM_FULL(NUM_FULL), .BASE(BASE), .STRIDE(STRIDE)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .cfg_wr    (cfg_wr),
  .cfg_ofs   (cfg_ofs),
  .cfg_rdata (cfg_rdata),
  .loc_addr  (loc_addr),
  .bus_addr  (bus_addr),
  .xl_hit    (xl_hit),
  .xl_miss   (xl_miss)
);

// File: tb/obwin_xlate_tb.sv
`timescale 1ns/1ps
module obwin_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_ofs = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [63:0] loc_addr = '0;
  logic [63:0] bus_addr;
  logic        xl_hit;
  logic        xl_miss;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  logic [63:0] m_la [2];
  logic [63:0] m_pa [2];
  logic [31:0] m_sa [3];

  always #2 clk = ~clk;

  obwin_xlate dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_ofs(cfg_ofs), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .loc_addr(loc_addr), .bus_addr(bus_addr),
    .xl_hit(xl_hit), .xl_miss(xl_miss)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [7:0] ro(input int w, input int f);
    return 8'(8'h68 + 20 * w + f);
  endfunction

  function automatic logic mapped(input logic [7:0] a);
    return a[1:0] == 2'b00 && a >= 8'h68 && a <= 8'h90;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    logic [31:0] v = '0;
    for (int w = 0; w < 2; w++) begin
      if (a == ro(w, 0))  v = m_la[w][31:0];
      if (a == ro(w, 4))  v = m_la[w][63:32];
      if (a == ro(w, 8))  v = m_sa[w];
      if (a == ro(w, 12)) v = m_pa[w][31:0];
      if (a == ro(w, 16)) v = m_pa[w][63:32];
    end
    if (a == 8'h90) v = m_sa[2];
    return v;
  endfunction

  // expected translation computed from the R4..R7 arithmetic
  task automatic model(input logic [63:0] a, output logic h, output logic [63:0] b);
    h = 1'b0; b = '0;
    for (int w = 1; w >= 0; w--) begin
      logic [31:0] len;
      len = (~(m_sa[w] & 32'hFFFF_FFFE)) + 32'd1;
      if (len == 32'd0) len = 32'hFFFF_FFFF;
      if (m_sa[w][0] && a >= m_la[w] && (a - m_la[w]) < {32'd0, len}) begin
        h = 1'b1; b = m_pa[w] + (a - m_la[w]);
      end
    end
  endtask

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_ofs = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    for (int w = 0; w < 2; w++) begin
      if (a == ro(w, 0))  m_la[w][31:0]  = d;
      if (a == ro(w, 4))  m_la[w][63:32] = d;
      if (a == ro(w, 8))  m_sa[w]        = d;
      if (a == ro(w, 12)) m_pa[w][31:0]  = d;
      if (a == ro(w, 16)) m_pa[w][63:32] = d;
    end
    if (a == 8'h90) m_sa[2] = d;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk);
    cfg_ofs = a;
    @(negedge clk);
    e = exp_rd(a);
    chk(cfg_rdata == e, tag, 64'(cfg_rdata), 64'(e));
  endtask

  task automatic xl(input logic [63:0] a, input string tag);
    logic h; logic [63:0] b;
    @(negedge clk);
    loc_addr = a;
    @(negedge clk);
    model(a, h, b);
    chk(xl_hit == h && xl_miss == !h && bus_addr == b, tag, {xl_hit, bus_addr[62:0]}, {h, b[62:0]});
  endtask

  task automatic xl_lit(input logic [63:0] a, input logic h, input logic [63:0] b, input string tag);
    @(negedge clk);
    loc_addr = a;
    @(negedge clk);
    chk(xl_hit == h && xl_miss == !h && bus_addr == b, tag, bus_addr, b);
  endtask

  task automatic put_win(input int w, input logic [63:0] la, input logic [63:0] pa, input logic [31:0] sa);
    wr(ro(w, 0), la[31:0]);  wr(ro(w, 4), la[63:32]);
    wr(ro(w, 12), pa[31:0]); wr(ro(w, 16), pa[63:32]);
    wr(ro(w, 8), sa);
  endtask

  localparam logic [63:0] LA0 = 64'h0000_0001_8000_0000;

  initial begin
    for (int w = 0; w < 2; w++) begin m_la[w] = '0; m_pa[w] = '0; end
    for (int w = 0; w < 3; w++) m_sa[w] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: clean state straight after reset
    chk(xl_miss && !xl_hit && bus_addr == '0 && cfg_rdata == '0, "R1 reset outputs",
        {xl_miss, bus_addr[62:0]}, {1'b1, 63'd0});
    for (int a = 0; a < 256; a += 4) rd(8'(a), "R1 reset read");
    xl(64'h0, "R1 reset miss"); xl(LA0, "R1 reset miss");

    // R2 / R10: distinct pattern in every mapped register, full offset sweep
    for (int a = 8'h68; a <= 8'h90; a += 4) wr(8'(a), 32'hC0DE_0000 | 32'(a) << 4 | 32'(a));
    for (int a = 0; a < 256; a++) rd(8'(a), mapped(8'(a)) ? "R2 readback" : "R10 unmapped read");

    // R3: half writes touch one half only
    wr(ro(0, 0), 32'h1111_2222); rd(ro(0, 0), "R3 low write"); rd(ro(0, 4), "R3 high kept");
    wr(ro(1, 16), 32'h3333_4444); rd(ro(1, 16), "R3 high write"); rd(ro(1, 12), "R3 low kept");

    // R10: writes to every unmapped offset are dropped
    for (int a = 0; a < 256; a++) if (!mapped(8'(a))) wr(8'(a), 32'hFFFF_FFFF);
    for (int a = 8'h68; a <= 8'h90; a += 4) rd(8'(a), "R10 write ignored");

    // clear everything
    for (int a = 8'h68; a <= 8'h90; a += 4) wr(8'(a), 32'h0);
    xl(LA0, "R9 cleared miss");

    // R4: disabled window never matches
    put_win(0, LA0, 64'h0000_0000_4000_0000, 32'hFFF0_0000);
    xl(LA0, "R4 disabled"); xl(LA0 + 64'h10, "R4 disabled");
    wr(ro(0, 8), 32'hFFF0_0001);
    xl_lit(LA0 + 64'h44, 1'b1, 64'h0000_0000_4000_0044, "R5 enabled hit");

    // R5: every power-of-two length, both edges
    for (int k = 4; k < 32; k++) begin
      logic [31:0] sa; logic [63:0] len;
      sa  = ~((32'd1 << k) - 32'd1) | 32'd1;
      len = 64'd1 << k;
      wr(ro(0, 8), sa);
      xl(LA0 - 64'd1, "R5 below base");
      xl(LA0, "R5 base");
      xl(LA0 + len - 64'd1, "R5 last byte");
      xl(LA0 + len, "R5 past end");
    end
    // R5: zero length becomes the maximum; bit 1 of the mask
    wr(ro(0, 8), 32'h0000_0001);
    xl_lit(LA0 + 64'hFFFF_FFFE, 1'b1, 64'h0000_0000_4000_0000 + 64'hFFFF_FFFE, "R5 zero len max");
    xl_lit(LA0 + 64'hFFFF_FFFF, 1'b0, 64'h0, "R5 zero len end");
    wr(ro(0, 8), 32'h0000_0003);
    xl(LA0 + 64'hFFFF_FFFD, "R5 odd mask in");
    xl(LA0 + 64'hFFFF_FFFE, "R5 odd mask out");

    // R6: translated address wraps at 64 bits
    put_win(0, LA0, 64'hFFFF_FFFF_FFFF_FFF0, 32'hFFFF_F001);
    xl_lit(LA0 + 64'h20, 1'b1, 64'h10, "R6 wrap");
    xl_lit(LA0 + 64'h8, 1'b1, 64'hFFFF_FFFF_FFFF_FFF8, "R6 offset");

    // R7: overlapping windows, window 0 wins
    put_win(0, LA0, 64'h0000_0000_4000_0000, 32'hFFF0_0001);
    put_win(1, 64'h0000_0001_8008_0000, 64'hABCD_0000_0000_0000, 32'hF000_0001);
    xl_lit(64'h0000_0001_8008_0000, 1'b1, 64'h0000_0000_4008_0000, "R7 overlap low wins");
    xl_lit(64'h0000_0001_800F_FFFF, 1'b1, 64'h0000_0000_400F_FFFF, "R7 overlap top");
    xl_lit(64'h0000_0001_8010_0000, 1'b1, 64'hABCD_0000_0008_0000, "R7 window 1 only");
    xl(64'h0000_0001_7FFF_FFFF, "R7 below both");

    // R11: outputs move only at the edge
    @(negedge clk); loc_addr = 64'h0;
    #1 chk(xl_hit == 1'b0 && xl_miss == 1'b1, "R11 held before edge", {63'd0, xl_hit}, 64'd0);
    @(negedge clk);
    chk(xl_miss == 1'b1 && bus_addr == '0, "R11 updated after edge", bus_addr, 64'd0);

    // R8: trailing window stores its span but never maps
    wr(ro(0, 8), 32'h0); wr(ro(1, 8), 32'h0);
    wr(8'h90, 32'hFFFF_FFF1);
    rd(8'h90, "R8 tail readback");
    xl(64'h0, "R8 tail no hit"); xl(LA0, "R8 tail no hit"); xl(64'hFFFF_FFFF_FFFF_FFFF, "R8 tail no hit");
    wr(8'h90, 32'h0000_0001);
    xl(64'h0000_0000_0000_0040, "R8 tail no hit");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule